// File: doc/BRIEF.md
# Four-Channel Bus-Hold DMA Controller

This block moves data between four peripherals and memory without help from the host processor. Each channel is programmed with a start address, a transfer count and a mode word. When an enabled channel raises its request line, the controller asks the host for the system bus with a hold request. It waits for the hold acknowledge and then runs bus cycles. In each cycle it puts the channel's current address on the bus, raises either a memory read or a memory write strobe, and asserts that channel's acknowledge toward the peripheral.

Transfers are fly-by. In the cycle where its acknowledge is high, the peripheral drives the data or takes it directly, so no data passes through the controller. After each bus cycle the host owns the next cycle, which keeps long transfers from shutting the processor out. A channel runs in one of three modes. Single mode gives one unit per bus grant. Block mode runs the whole count once started. Demand mode runs for as long as the request line stays high. When several channels request at once, the lowest-numbered one wins.

Top module: `busdma_ctrl`

## Requirements
- R1: Channel i owns request input `dreq_i[i]` and acknowledge output `dack_o[i]`. During a bus cycle for channel i, `dack_o[i]` is the only acknowledge bit that is high.
- R2: The cycle after an eligible request is sampled, `hold_req_o` goes high. No acknowledge, strobe or non-zero address appears until `hold_ack_i` has been sampled high. The first bus cycle is the cycle after that sample.
- R3: While `hold_ack_i` stays low, `hold_req_o` stays high and no bus cycle starts. A host that acknowledges d cycles after the hold request appears delays the first acknowledge to d+1 cycles after the hold request.
- R4: Every bus cycle is followed by a cycle with no acknowledge and no strobe, which the host uses.
- R5: Single mode (mode field 0 or 3) performs one transfer and then drops `hold_req_o` for at least one cycle before the next request is taken.
- R6: Block mode (mode field 1) runs every remaining transfer once the first bus cycle has started, even if the request line falls. Hold stays high for the whole block, and channels of lower number do not preempt it.
- R7: Demand mode (mode field 2) keeps transferring while its request is high. When the request falls it releases hold and keeps its remaining count, and it resumes when the request returns.
- R8: Among eligible requests, the lowest channel number gets the next bus cycle.
- R9: Each bus cycle presents the channel's current address. The address then increments by one and the remaining count decrements by one.
- R10: `tc_o` is high in exactly the bus cycle that moves the last unit. The channel's `done_o` bit then sets and stays set. Writing that channel's mode word clears it.
- R11: A channel that is disabled, done, or has a count of zero is ignored. When no eligible request remains, `hold_req_o` falls and the host keeps the bus.
- R12: Programming uses `cfg_we`, `cfg_ch` and `cfg_sel`: select 0 loads the address, select 1 loads the count, select 2 loads the mode word, and select 3 does nothing. In the mode word, bits [1:0] are the mode, bit 2 is the direction and bit 3 is the enable. Direction 1 (peripheral to memory) pulses `bus_mem_wr_o`. Direction 0 (memory to peripheral) pulses `bus_mem_rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel selected for the write |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 mode |
| cfg_wdata | input | 16 | Write data |
| dreq_i | input | 4 | Peripheral request lines |
| hold_ack_i | input | 1 | Host has released the bus |
| hold_req_o | output | 1 | Request for the bus toward the host |
| dack_o | output | 4 | Per-channel acknowledge during its bus cycle |
| bus_addr_o | output | 16 | Memory address driven in a bus cycle, zero otherwise |
| bus_mem_rd_o | output | 1 | Memory read strobe |
| bus_mem_wr_o | output | 1 | Memory write strobe |
| tc_o | output | 1 | Terminal count, high in the final bus cycle of a channel |
| done_o | output | 4 | Sticky per-channel completion flags |

## Verification
The bench drives a host model with a programmable acknowledge delay. If the design ran a bus cycle before the acknowledge, the first acknowledge would come early. If it skipped the host gap, acknowledges would appear back to back.

A demand-mode request is pulled low in the middle of a transfer. A design that treated demand like block would finish the count instead of pausing at exactly three transfers. A block request is dropped right after it starts. A design that treated block like demand would stop early.

Simultaneous requests on channels 1 and 3 expose a reversed priority. Disabled, zero-count and already-finished channels held at request must never raise hold. Reprogramming a finished channel must clear its done flag.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE  = 2'd0,
    XM_BLOCK   = 2'd1,
    XM_DEMAND  = 2'd2,
    XM_SINGLE2 = 2'd3
  } xmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_XFER = 2'd2,
    SQ_GAP  = 2'd3
  } seq_e;

  typedef struct packed {
    logic   en;
    logic   dir;
    xmode_e mode;
  } chcfg_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
endpackage

// File: rtl/busdma_chan.sv
module busdma_chan
  import busdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int WD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_mode,
  input  logic [WD-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output chcfg_t        cfg_q,
  output logic          done_q
);
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          addr_en, cnt_en, done_en, done_d, last;

  assign last = (cnt_q == CW'(1));

  always_comb begin
    addr_en = wr_addr | step;
    addr_d  = wr_addr ? wdata[AW-1:0] : addr_q + AW'(1);
    cnt_en  = wr_cnt | step;
    cnt_d   = wr_cnt ? wdata[CW-1:0] : cnt_q - CW'(1);
    done_en = wr_mode | (step & last);
    done_d  = ~wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (wr_mode) cfg_q  <= chcfg_t'(wdata[3:0]);
      if (done_en) done_q <= done_d;
    end
  end
endmodule

// File: rtl/busdma_prio.sv
module busdma_prio #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/busdma_seq.sv
module busdma_seq
  import busdma_pkg::*;
#(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          hold_ack,
  input  logic          keep_cur,
  input  logic          single_cur,
  output seq_e          st_q,
  output logic [IW-1:0] cur_q
);
  seq_e          st_d;
  logic [IW-1:0] win;
  logic          any, cur_en;

  busdma_prio #(.N(N)) u_prio (.req(elig), .any(any), .idx(win));

  always_comb begin
    st_d   = st_q;
    cur_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (any) st_d = SQ_WAIT;
      SQ_WAIT: begin
        if (!any) st_d = SQ_IDLE;
        else if (hold_ack) begin
          st_d   = SQ_XFER;
          cur_en = 1'b1;
        end
      end
      SQ_XFER: st_d = single_cur ? SQ_IDLE : SQ_GAP;
      SQ_GAP: begin
        if (keep_cur) begin
          if (hold_ack) st_d = SQ_XFER;
        end else if (any) begin
          if (hold_ack) begin
            st_d   = SQ_XFER;
            cur_en = 1'b1;
          end else begin
            st_d = SQ_WAIT;
          end
        end else begin
          st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cur_q <= '0;
    end else begin
      st_q <= st_d;
      if (cur_en) cur_q <= win;
    end
  end
endmodule

// File: rtl/busdma_ctrl.sv
module busdma_ctrl
  import busdma_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int AW  = 16,
  parameter  int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WD  = (AW > CW) ? AW : CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [WD-1:0]  cfg_wdata,
  input  logic [NCH-1:0] dreq_i,
  input  logic           hold_ack_i,
  output logic           hold_req_o,
  output logic [NCH-1:0] dack_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic           bus_mem_rd_o,
  output logic           bus_mem_wr_o,
  output logic           tc_o,
  output logic [NCH-1:0] done_o
);
  logic          rs_meta, rs_n;
  logic [AW-1:0] addr_a [NCH];
  logic [CW-1:0] cnt_a  [NCH];
  chcfg_t        cfg_a  [NCH];
  logic [NCH-1:0] elig;
  seq_e          st;
  logic [CHW-1:0] cur;
  logic          in_xfer, keep_cur, single_cur;
  chcfg_t        cur_cfg;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign in_xfer = (st == SQ_XFER);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_me;
    assign sel_me = cfg_we && (cfg_ch == CHW'(g));
    busdma_chan #(.AW(AW), .CW(CW), .WD(WD)) u_chan (
      .clk    (clk),
      .rst_n  (rs_n),
      .wr_addr(sel_me && cfg_sel == SEL_ADDR),
      .wr_cnt (sel_me && cfg_sel == SEL_CNT),
      .wr_mode(sel_me && cfg_sel == SEL_MODE),
      .wdata  (cfg_wdata),
      .step   (in_xfer && cur == CHW'(g)),
      .addr_q (addr_a[g]),
      .cnt_q  (cnt_a[g]),
      .cfg_q  (cfg_a[g]),
      .done_q (done_o[g])
    );
    assign elig[g] = cfg_a[g].en & ~done_o[g] & (cnt_a[g] != '0) & dreq_i[g];
  end

  assign cur_cfg    = cfg_a[cur];
  assign keep_cur   = (cur_cfg.mode == XM_BLOCK) && !done_o[cur] && (cnt_a[cur] != '0);
  assign single_cur = !((cur_cfg.mode == XM_BLOCK) || (cur_cfg.mode == XM_DEMAND));

  busdma_seq #(.N(NCH)) u_seq (
    .clk       (clk),
    .rst_n     (rs_n),
    .elig      (elig),
    .hold_ack  (hold_ack_i),
    .keep_cur  (keep_cur),
    .single_cur(single_cur),
    .st_q      (st),
    .cur_q     (cur)
  );

  assign hold_req_o   = (st != SQ_IDLE);
  assign dack_o       = in_xfer ? (NCH'(1) << cur) : '0;
  assign bus_addr_o   = in_xfer ? addr_a[cur] : '0;
  assign bus_mem_wr_o = in_xfer & cur_cfg.dir;
  assign bus_mem_rd_o = in_xfer & ~cur_cfg.dir;
  assign tc_o         = in_xfer && (cnt_a[cur] == CW'(1));
endmodule

// File: rtl/busdma_chk.sv
module busdma_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic [NCH-1:0] dack,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           tc,
  input logic [NCH-1:0] done
);
  AST_DRIVE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> (hold_req && hold_ack)); // R2

  AST_SINGLE_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack)); // R1

  AST_HOST_GETS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |=> !(|dack)); // R4

  AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> ((|dack) && !(mem_rd && mem_wr))); // R12

  AST_TC_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (|dack)); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_done
    AST_DONE_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[i]) |-> $past(tc && dack[i])); // R10
  end
endmodule

bind busdma_ctrl busdma_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold_req(hold_req_o),
  .hold_ack(hold_ack_i),
  .dack    (dack_o),
  .mem_rd  (bus_mem_rd_o),
  .mem_wr  (bus_mem_wr_o),
  .tc      (tc_o),
  .done    (done_o)
);

// File: tb/tb_busdma_ctrl.sv
`timescale 1ns/1ps
module tb_busdma_ctrl;
  logic        clk, rst_n, cfg_we, hold_ack_i;
  logic [1:0]  cfg_ch, cfg_sel;
  logic [15:0] cfg_wdata, bus_addr_o;
  logic [3:0]  dreq_i, dack_o, done_o;
  logic        hold_req_o, bus_mem_rd_o, bus_mem_wr_o, tc_o;

  busdma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq_i(dreq_i), .hold_ack_i(hold_ack_i),
    .hold_req_o(hold_req_o), .dack_o(dack_o), .bus_addr_o(bus_addr_o),
    .bus_mem_rd_o(bus_mem_rd_o), .bus_mem_wr_o(bus_mem_wr_o), .tc_o(tc_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit run = 0, ended = 0;
  int ack_delay = 0, ack_cnt = 0;
  int n_xfer [4];
  int last_addr [4];
  int first_ch = -1, hold_cyc = -1, dack_cyc = -1, hold_falls = 0, b2b = 0;
  bit prev_dack = 0, prev_hold = 0;

  // behavioural reference model: state 0 idle, 1 waiting, 2 transfer, 3 host gap
  int m_st, m_cur;
  int m_addr [4], m_cnt [4], m_mode [4];
  bit m_dir [4], m_en [4], m_done [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cur = 0;
      for (int i = 0; i < 4; i++) begin
        m_addr[i] = 0; m_cnt[i] = 0; m_mode[i] = 0;
        m_dir[i] = 0; m_en[i] = 0; m_done[i] = 0;
      end
    end else begin
      int win;
      bit keep, single;
      win = -1;
      for (int i = 3; i >= 0; i--)
        if (m_en[i] && !m_done[i] && m_cnt[i] != 0 && dreq_i[i]) win = i;
      case (m_st)
        0: if (win >= 0) m_st = 1;
        1: if (win < 0) m_st = 0;
           else if (hold_ack_i) begin m_cur = win; m_st = 2; end
        2: begin
          single = !(m_mode[m_cur] == 1 || m_mode[m_cur] == 2);
          m_addr[m_cur] = (m_addr[m_cur] + 1) & 16'hFFFF;
          m_cnt[m_cur]  = m_cnt[m_cur] - 1;
          if (m_cnt[m_cur] == 0) m_done[m_cur] = 1;
          m_st = single ? 0 : 3;
        end
        default: begin
          keep = (m_mode[m_cur] == 1) && !m_done[m_cur] && m_cnt[m_cur] != 0;
          if (keep) begin
            if (hold_ack_i) m_st = 2;
          end else if (win >= 0) begin
            if (hold_ack_i) begin m_cur = win; m_st = 2; end
            else m_st = 1;
          end else m_st = 0;
        end
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_addr[cfg_ch] = cfg_wdata;
          2'd1: m_cnt[cfg_ch]  = cfg_wdata;
          2'd2: begin
            m_mode[cfg_ch] = cfg_wdata[1:0];
            m_dir[cfg_ch]  = cfg_wdata[2];
            m_en[cfg_ch]   = cfg_wdata[3];
            m_done[cfg_ch] = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // compare, monitor and host model, away from the active edge
  always @(negedge clk) begin
    if (run && !ended) begin
      int e_dack, e_addr, e_done;
      bit xf;
      xf     = (m_st == 2);
      e_dack = xf ? (1 << m_cur) : 0;
      e_addr = xf ? m_addr[m_cur] : 0;
      e_done = {m_done[3], m_done[2], m_done[1], m_done[0]};
      chk(hold_req_o == (m_st != 0), "R2 hold_req", hold_req_o, m_st != 0);
      chk(dack_o == e_dack, "R1 dack", dack_o, e_dack);
      chk(bus_addr_o == e_addr, "R9 address", bus_addr_o, e_addr);
      chk(bus_mem_wr_o == (xf && m_dir[m_cur]), "R12 mem_wr", bus_mem_wr_o, xf && m_dir[m_cur]);
      chk(bus_mem_rd_o == (xf && !m_dir[m_cur]), "R12 mem_rd", bus_mem_rd_o, xf && !m_dir[m_cur]);
      chk(tc_o == (xf && m_cnt[m_cur] == 1), "R10 tc", tc_o, xf && m_cnt[m_cur] == 1);
      chk(done_o == e_done, "R10 done", done_o, e_done);
      for (int i = 0; i < 4; i++)
        if (dack_o[i]) begin
          n_xfer[i]++;
          last_addr[i] = bus_addr_o;
          if (first_ch < 0) first_ch = i;
          if (dack_cyc < 0) dack_cyc = cyc;
        end
      if (prev_dack && |dack_o) b2b++;
      prev_dack = |dack_o;
      if (prev_hold && !hold_req_o) hold_falls++;
      if (!prev_hold && hold_req_o && hold_cyc < 0) hold_cyc = cyc;
      prev_hold = hold_req_o;
    end
    if (hold_req_o) begin
      ack_cnt++;
      hold_ack_i = (ack_cnt > ack_delay);
    end else begin
      ack_cnt = 0;
      hold_ack_i = 1'b0;
    end
    cyc++;
    if (cyc > 100000 && !ended) begin
      ended = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(data);
    tick();
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input int addr, input int cnt, input int mode);
    wr(ch, 0, addr);
    wr(ch, 1, cnt);
    wr(ch, 2, mode);
  endtask

  task automatic clear_mon();
    for (int i = 0; i < 4; i++) n_xfer[i] = 0;
    first_ch = -1; hold_cyc = -1; dack_cyc = -1; hold_falls = 0; b2b = 0;
  endtask

  task automatic wait_done(input int ch);
    for (int k = 0; k < 500 && !done_o[ch]; k++) tick();
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_sel = 0; cfg_wdata = 0;
    dreq_i = 0; hold_ack_i = 0;
    for (int i = 0; i < 4; i++) begin n_xfer[i] = 0; last_addr[i] = 0; end
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    run = 1;
    repeat (4) tick();
    chk(hold_req_o == 0 && dack_o == 0, "R2 reset idle", {hold_req_o, dack_o}, 0);
    chk(done_o == 0, "R10 reset done", done_o, 0);

    // single mode, peripheral to memory (mode word: en=1 dir=1 mode=0)
    clear_mon();
    prog(2, 16'h0100, 3, 12);
    dreq_i[2] = 1;
    wait_done(2);
    dreq_i[2] = 0;
    repeat (4) tick();
    chk(n_xfer[2] == 3, "R5 single transfer count", n_xfer[2], 3);
    chk(hold_falls == 3, "R5 hold released per unit", hold_falls, 3);
    chk(last_addr[2] == 16'h0102, "R9 last address", last_addr[2], 16'h0102);

    // block mode, memory to peripheral; request dropped after start
    clear_mon();
    prog(1, 16'h2000, 5, 9);
    dreq_i[1] = 1;
    for (int k = 0; k < 50 && !dack_o[1]; k++) tick();
    dreq_i[1] = 0;
    wait_done(1);
    repeat (4) tick();
    chk(n_xfer[1] == 5, "R6 block runs full count", n_xfer[1], 5);
    chk(hold_falls == 1, "R6 hold kept through block", hold_falls, 1);
    chk(b2b == 0, "R4 host cycle between transfers", b2b, 0);

    // demand mode: pause when request drops, resume later
    clear_mon();
    prog(0, 16'h3000, 8, 14);
    dreq_i[0] = 1;
    for (int k = 0; k < 100 && n_xfer[0] < 3; k++) tick();
    dreq_i[0] = 0;
    repeat (10) tick();
    chk(n_xfer[0] == 3, "R7 demand pauses", n_xfer[0], 3);
    chk(done_o[0] == 0 && hold_req_o == 0, "R7 paused, hold released", {done_o[0], hold_req_o}, 0);
    dreq_i[0] = 1;
    wait_done(0);
    dreq_i[0] = 0;
    repeat (4) tick();
    chk(n_xfer[0] == 8, "R7 demand resumes to completion", n_xfer[0], 8);
    chk(last_addr[0] == 16'h3007, "R9 demand final address", last_addr[0], 16'h3007);

    // priority: channels 1 and 3 together
    clear_mon();
    prog(3, 16'h4000, 2, 14);
    prog(1, 16'h5000, 2, 14);
    dreq_i[3] = 1; dreq_i[1] = 1;
    wait_done(1);
    wait_done(3);
    dreq_i = 0;
    repeat (4) tick();
    chk(first_ch == 1, "R8 lowest channel first", first_ch, 1);
    chk(n_xfer[1] == 2 && n_xfer[3] == 2, "R8 both served", n_xfer[1] * 16 + n_xfer[3], 34);

    // ignored channels: done ch2, disabled ch3, zero-count ch0
    clear_mon();
    prog(3, 16'h6000, 4, 2);
    prog(0, 16'h7000, 0, 8);
    dreq_i = 4'b1101;
    repeat (20) tick();
    chk(hold_req_o == 0 && hold_cyc < 0, "R11 ignored requests", hold_cyc, -1);
    chk(n_xfer[0] + n_xfer[2] + n_xfer[3] == 0, "R11 no transfers", n_xfer[0] + n_xfer[2] + n_xfer[3], 0);
    dreq_i = 0;
    repeat (2) tick();

    // delayed host acknowledge; reprogram clears done
    chk(done_o[1] == 1, "R10 done sticky", done_o[1], 1);
    clear_mon();
    ack_delay = 4;
    prog(1, 16'h8000, 2, 8);
    chk(done_o[1] == 0, "R10 mode write clears done", done_o[1], 0);
    dreq_i[1] = 1;
    wait_done(1);
    dreq_i[1] = 0;
    repeat (4) tick();
    chk(dack_cyc - hold_cyc == 5, "R3 wait for acknowledge", dack_cyc - hold_cyc, 5);
    chk(n_xfer[1] == 2, "R3 transfers after delay", n_xfer[1], 2);
    ack_delay = 0;

    ended = 1;
    summary();
    $finish;
  end
endmodule